// File: doc/BRIEF.md
# Delayed and Plain One-Shot Timer

A down-counting one-shot timer. Once started, it loads a reload value on a count-clock tick and decrements on each later tick. When the counter passes through zero (an underflow), the output flip-flop toggles and a one-cycle request strobe fires. The mode input, sampled on the load tick, picks one of two shapes:

- **Plain shot:** the output toggles at the load tick, toggles back at the single underflow, and the counter stops.
- **Delayed shot:** the first underflow ends a delay phase and toggles the output. The counter is then reloaded, and the second underflow toggles the output back and stops the counter.

A start can come from a register write or from an external start input. A register write can also stop the timer. Conflicts between these requests and an underflow in the same clock are settled by a fixed priority.

The counter value is read through a small valid/ready channel:

- A request is taken when `rd_valid` and `rd_ready` are both high.
- The snapshot is held on `rd_data` while `rd_data_valid` is high and `rd_data_ready` is low.
- `rd_ready` is high whenever no response is pending or the pending one is being taken in the same cycle.

Top module: `oneshot_timer`

## Requirements
- R1: After reset, shot_out and shot_req are low, rd_data_valid is low, the timer is idle and the counter reads 0.
- R2: While idle, a write with wr_en=1 and wr_data=1, or a high ext_start, arms the timer. On the next cycle with tick high, the counter loads reload_val.
- R3: With mode=0 on the load tick, shot_out toggles on that tick. It toggles back on the underflow tick, which is the (reload_val+1)-th tick after the load. The timer then goes idle.
- R4: With mode=1 on the load tick, shot_out does not toggle at load. It toggles on the first underflow, reload_val+1 ticks after the load. On the next tick the counter becomes reload_val-1. It toggles back on the second underflow, reload_val+1 ticks after the first, and the timer then goes idle.
- R5: In mode=1 with reload_val=0, the second underflow happens on the tick right after the first.
- R6: Every underflow that toggles shot_out raises shot_req for exactly the cycle in which the toggled value first appears. No other event raises it.
- R7: An underflow leaves the counter at all ones (0xFFFFFF for the default 24-bit width). A read taken before the next tick returns that value.
- R8: A write with wr_en=1 and wr_data=0 stops the timer at once. It wins over ext_start in the same cycle. The counter and shot_out then hold.
- R9: When the final underflow and a high ext_start fall in the same cycle, the timer stops and the start is dropped.
- R10: When the final underflow and a write with wr_en=1, wr_data=1 fall in the same cycle, the timer re-arms and a new shot loads on the next tick.
- R11: A read request is taken when rd_valid and rd_ready are both high, where rd_ready = !rd_data_valid or rd_data_ready. The response carries the counter value of the accepting cycle and holds while rd_data_valid is high and rd_data_ready is low.
- R12: Start requests while armed or running have no effect, apart from the case in R10.
- R13: In cycles with tick low, the counter and shot_out do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-clock enable |
| mode | input | 1 | 0 plain shot, 1 delayed shot (sampled at load) |
| reload_val | input | CNT_W | Reload value |
| ext_start | input | 1 | External start request |
| wr_en | input | 1 | Enable-bit register write strobe |
| wr_data | input | 1 | Written enable value (1 start, 0 stop) |
| rd_valid | input | 1 | Counter read request valid |
| rd_ready | output | 1 | Counter read request ready |
| rd_data_valid | output | 1 | Read response valid |
| rd_data_ready | input | 1 | Read response ready |
| rd_data | output | CNT_W | Read response: counter snapshot |
| shot_out | output | 1 | Output flip-flop |
| shot_req | output | 1 | One-cycle request strobe on underflow |

## Verification
The shot is driven with single hand-placed ticks, ticks on every cycle, and ticks on every second or third cycle, in both modes and with reload values of 0, 2, 3, 4, 7 and 10. This separates the load tick, phase lengths and reload-minus-one behaviour from tick gating. Start and stop requests are placed exactly on the final-underflow cycle and on idle cycles, which tells the three priority rules apart. Reads are made with hand-timed requests right after an underflow, to see the all-ones value, and with pseudo-random valid and ready patterns that exercise back-pressure on the response.

// File: rtl/ost_pkg.sv
`timescale 1ns/1ps
package ost_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_DELAY, ST_OUTPUT} ost_state_e;
  typedef enum logic [1:0] {OP_HOLD, OP_LOAD, OP_LOAD_M1, OP_DEC} cnt_op_e;
endpackage

// File: rtl/ost_counter.sv
`timescale 1ns/1ps
module ost_counter
  import ost_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  cnt_op_e          op,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_zero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick) begin
      case (op)
        OP_LOAD:    cnt <= reload_val;
        OP_LOAD_M1: cnt <= reload_val - ONE;
        OP_DEC:     cnt <= cnt - ONE;
        default:    cnt <= cnt;
      endcase
    end
  end

  assign cnt_zero = (cnt == '0);

  // R13
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/ost_ctrl.sv
`timescale 1ns/1ps
module ost_ctrl
  import ost_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       mode,
  input  logic       ext_start,
  input  logic       wr_en,
  input  logic       wr_data,
  input  logic       cnt_zero,
  input  logic       reload_zero,
  output cnt_op_e    op,
  output logic       out_q,
  output logic       strobe_q
);
  ost_state_e st, st_n;
  logic due, due_n;
  logic flip, fire, last;
  logic stop_wr, start_wr;

  assign stop_wr  = wr_en & ~wr_data;
  assign start_wr = wr_en & wr_data;

  always_comb begin
    st_n  = st;
    due_n = due;
    op    = OP_HOLD;
    flip  = 1'b0;
    fire  = 1'b0;
    last  = 1'b0;
    if (stop_wr) begin
      st_n  = ST_IDLE;
      due_n = 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start_wr || ext_start) st_n = ST_ARMED;
        end
        ST_ARMED: begin
          if (tick) begin
            op = OP_LOAD;
            if (mode) begin
              st_n = ST_DELAY;
            end else begin
              st_n = ST_OUTPUT;
              flip = 1'b1;
            end
          end
        end
        ST_DELAY: begin
          if (tick) begin
            op = OP_DEC;
            if (cnt_zero) begin
              flip  = 1'b1;
              fire  = 1'b1;
              st_n  = ST_OUTPUT;
              due_n = 1'b1;
            end
          end
        end
        ST_OUTPUT: begin
          if (tick) begin
            if (due) begin
              due_n = 1'b0;
              if (reload_zero) last = 1'b1;
              else op = OP_LOAD_M1;
            end else begin
              op = OP_DEC;
              if (cnt_zero) last = 1'b1;
            end
            if (last) begin
              flip = 1'b1;
              fire = 1'b1;
              st_n = start_wr ? ST_ARMED : ST_IDLE;
            end
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      due      <= 1'b0;
      out_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      st       <= st_n;
      due      <= due_n;
      out_q    <= out_q ^ flip;
      strobe_q <= fire;
    end
  end

  // R6
  strobe_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> (out_q != $past(out_q)));
  // R8
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data) |=> (st == ST_IDLE));
  // R9
  stop_over_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OUTPUT && fire && ext_start && !wr_en) |=> (st == ST_IDLE));
endmodule

// File: rtl/ost_readport.sv
`timescale 1ns/1ps
module ost_readport #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             rd_valid,
  output logic             rd_ready,
  output logic             rd_data_valid,
  input  logic             rd_data_ready,
  output logic [CNT_W-1:0] rd_data
);
  assign rd_ready = !rd_data_valid || rd_data_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data_valid <= 1'b0;
      rd_data       <= '0;
    end else if (rd_valid && rd_ready) begin
      rd_data_valid <= 1'b1;
      rd_data       <= cnt;
    end else if (rd_data_ready) begin
      rd_data_valid <= 1'b0;
    end
  end

  // R11
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_valid && !rd_data_ready) |=> (rd_data_valid && $stable(rd_data)));
endmodule

// File: rtl/oneshot_timer.sv
`timescale 1ns/1ps
module oneshot_timer
  import ost_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             mode,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             ext_start,
  input  logic             wr_en,
  input  logic             wr_data,
  input  logic             rd_valid,
  output logic             rd_ready,
  output logic             rd_data_valid,
  input  logic             rd_data_ready,
  output logic [CNT_W-1:0] rd_data,
  output logic             shot_out,
  output logic             shot_req
);
  cnt_op_e          op;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;

  ost_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
    .ext_start(ext_start), .wr_en(wr_en), .wr_data(wr_data),
    .cnt_zero(cnt_zero), .reload_zero(reload_val == '0),
    .op(op), .out_q(shot_out), .strobe_q(shot_req)
  );

  ost_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .op(op),
    .reload_val(reload_val), .cnt(cnt), .cnt_zero(cnt_zero)
  );

  ost_readport #(.CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .cnt(cnt),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data_valid(rd_data_valid), .rd_data_ready(rd_data_ready),
    .rd_data(rd_data)
  );

  // R7
  underflow_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shot_req |-> (cnt == '1));
endmodule

// File: tb/oneshot_timer_test.sv
`timescale 1ns/1ps
module oneshot_timer_test;
  localparam int W = 24;
  localparam int MASK = 24'hFFFFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0, ext_start = 1'b0, wr_en = 1'b0, wr_data = 1'b0;
  logic [W-1:0] reload = '0;
  logic tick, tick_man = 1'b0, tick_gen = 1'b0;
  logic rd_valid, rd_data_ready, rd_man = 1'b0, rd_auto = 1'b0;
  logic rd_ready, rd_data_valid, shot_out, shot_req;
  logic [W-1:0] rd_data;
  int tick_div = 0, tdc = 0;
  logic [15:0] lf = 16'hACE1;

  int vectors = 0, fails = 0, sc = 0;
  string cur_req = "R1";
  bit run_cmp = 1'b0;

  always #2.5 clk = ~clk;

  assign tick          = (tick_div == 0) ? tick_man : tick_gen;
  assign rd_valid      = rd_auto ? lf[0] : rd_man;
  assign rd_data_ready = rd_auto ? lf[3] : 1'b1;

  oneshot_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .reload_val(reload),
    .ext_start(ext_start), .wr_en(wr_en), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data_valid(rd_data_valid),
    .rd_data_ready(rd_data_ready), .rd_data(rd_data),
    .shot_out(shot_out), .shot_req(shot_req)
  );

  // background tick and read-pattern generator
  always @(negedge clk) begin
    #1;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    if (tick_div > 0) begin
      tick_gen = (tdc == 0);
      tdc = (tdc + 1) % tick_div;
    end else begin
      tick_gen = 1'b0;
    end
  end

  // behavioural reference model
  int m_st, m_cnt, m_rd;
  bit m_due, m_out, m_req, m_rv, fin;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_due = 0; m_out = 0; m_req = 0; m_rv = 0; m_rd = 0;
    end else begin
      if (rd_valid && (!m_rv || rd_data_ready)) begin m_rv = 1; m_rd = m_cnt; end
      else if (rd_data_ready) m_rv = 0;
      m_req = 0;
      if (wr_en && !wr_data) begin m_st = 0; m_due = 0; end
      else if (m_st == 0) begin if (wr_en || ext_start) m_st = 1; end
      else if (tick) begin
        if (m_st == 1) begin
          m_cnt = int'(reload);
          if (mode) m_st = 2; else begin m_st = 3; m_out = !m_out; end
        end else if (m_st == 2) begin
          if (m_cnt == 0) begin m_out = !m_out; m_req = 1; m_st = 3; m_due = 1; end
          m_cnt = (m_cnt - 1) & MASK;
        end else begin
          fin = 0;
          if (m_due) begin
            m_due = 0;
            if (reload == 0) fin = 1; else m_cnt = int'(reload) - 1;
          end else begin
            if (m_cnt == 0) fin = 1;
            m_cnt = (m_cnt - 1) & MASK;
          end
          if (fin) begin m_out = !m_out; m_req = 1; m_st = (wr_en && wr_data) ? 1 : 0; end
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (run_cmp) begin
      if (shot_req) sc++;
      chk({cur_req, " shot_out"}, int'(shot_out), int'(m_out));
      chk({cur_req, " shot_req R6"}, int'(shot_req), int'(m_req));
      chk({cur_req, " rd_data_valid R11"}, int'(rd_data_valid), int'(m_rv));
      chk({cur_req, " rd_ready R11"}, int'(rd_ready), int'(!m_rv || rd_data_ready));
      if (m_rv) chk({cur_req, " rd_data R11"}, int'(rd_data), m_rd);
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask
  task automatic pulse();
    tick_man = 1'b1; step(); tick_man = 1'b0;
  endtask
  task automatic read_now(output int v);
    rd_man = 1'b1; step(); rd_man = 1'b0;
    v = int'(rd_data);
  endtask
  task automatic wr(input logic d);
    wr_en = 1'b1; wr_data = d; step(); wr_en = 1'b0; wr_data = 1'b0;
  endtask
  task automatic wait_final(output bit ok);
    ok = 0;
    for (int i = 0; i < 200; i++) begin
      if (m_st == 3 && !m_due && m_cnt == 0) begin ok = 1; break; end
      step();
    end
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int v, s0, o0;
    bit ok;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    run_cmp = 1'b1;
    // R1 reset state
    cur_req = "R1";
    chk("R1 shot_out", int'(shot_out), 0);
    chk("R1 shot_req", int'(shot_req), 0);
    chk("R1 rd_data_valid", int'(rd_data_valid), 0);
    read_now(v); chk("R1 counter", v, 0);

    // R2 / R3 plain shot, hand-placed ticks
    cur_req = "R3"; mode = 0; reload = 3; s0 = sc;
    wr(1'b1);
    pulse();
    chk("R3 toggle at load", int'(shot_out), 1);
    read_now(v); chk("R2 loaded reload", v, 3);
    repeat (3) pulse();
    chk("R3 still high before underflow", int'(shot_out), 1);
    pulse();
    chk("R3 back low at underflow", int'(shot_out), 0);
    chk("R6 strobe at underflow", int'(shot_req), 1);
    step();
    chk("R6 strobe one cycle", int'(shot_req), 0);
    read_now(v); chk("R7 all ones after underflow", v, MASK);
    pulse(); read_now(v); chk("R3 stopped after shot", v, MASK);
    chk("R3 one strobe", sc - s0, 1);

    // R4 / R7 delayed shot started by ext_start
    cur_req = "R4"; mode = 1; reload = 2; s0 = sc;
    ext_start = 1'b1; step(); ext_start = 1'b0;
    pulse();
    chk("R4 no toggle at load", int'(shot_out), 0);
    repeat (2) pulse();
    chk("R4 delay phase low", int'(shot_out), 0);
    pulse();
    chk("R4 first underflow toggles", int'(shot_out), 1);
    read_now(v); chk("R7 all ones in underflow cycle", v, MASK);
    pulse(); read_now(v); chk("R4 reload minus one", v, 1);
    pulse();
    chk("R4 output phase high", int'(shot_out), 1);
    pulse();
    chk("R4 second underflow toggles back", int'(shot_out), 0);
    chk("R4 two strobes", sc - s0, 2);

    // R5 delayed with zero reload
    cur_req = "R5"; reload = 0; s0 = sc;
    wr(1'b1);
    pulse(); pulse();
    chk("R5 first underflow", int'(shot_out), 1);
    pulse();
    chk("R5 second underflow next tick", int'(shot_out), 0);
    chk("R5 strobe", int'(shot_req), 1);
    step();
    chk("R5 two strobes", sc - s0, 2);

    // R8 stop beats ext_start; stop mid-run holds
    cur_req = "R8"; mode = 0; reload = 5; s0 = sc;
    ext_start = 1'b1; wr_en = 1'b1; wr_data = 1'b0; step();
    ext_start = 1'b0; wr_en = 1'b0;
    repeat (3) pulse();
    chk("R8 stayed idle, output", int'(shot_out), 0);
    read_now(v); chk("R8 stayed idle, counter", v, MASK);
    wr(1'b1);
    pulse(); pulse(); pulse();
    wr(1'b0);
    repeat (10) pulse();
    chk("R8 output held", int'(shot_out), 1);
    read_now(v); chk("R8 counter held", v, 3);
    chk("R8 no strobe", sc - s0, 0);

    // R9 final underflow beats ext_start
    cur_req = "R9"; tick_div = 1; mode = 0; reload = 4;
    wr(1'b1); s0 = sc; o0 = int'(shot_out);
    wait_final(ok); chk("R9 reached final", int'(ok), 1);
    ext_start = 1'b1; step(); ext_start = 1'b0;
    repeat (10) step();
    chk("R9 single strobe", sc - s0, 1);
    chk("R9 output after stop", int'(shot_out), o0);
    read_now(v); chk("R9 timer stopped", v, MASK);

    // R10 register start at final underflow re-arms
    cur_req = "R10";
    wr(1'b1); s0 = sc;
    wait_final(ok); chk("R10 reached final", int'(ok), 1);
    wr(1'b1);
    repeat (20) step();
    chk("R10 second shot ran", sc - s0, 2);

    // R11 / R12 random reads, ticks every third cycle, starts while running
    cur_req = "R12"; tick_div = 3; rd_auto = 1'b1; mode = 1; reload = 7;
    wr(1'b1); s0 = sc;
    repeat (10) step();
    ext_start = 1'b1; step(); ext_start = 1'b0;
    repeat (5) step();
    wr(1'b1);
    repeat (80) step();
    chk("R12 starts while running ignored", sc - s0, 2);
    cur_req = "R11"; tick_div = 2; mode = 0; reload = 10;
    ext_start = 1'b1; step(); ext_start = 1'b0;
    repeat (60) step();
    rd_auto = 1'b0; tick_div = 0;
    step(); step();

    // R13 no change without ticks
    cur_req = "R13"; reload = 9;
    wr(1'b1);
    pulse(); pulse();
    o0 = int'(shot_out);
    repeat (10) step();
    read_now(v); chk("R13 counter holds", v, 8);
    chk("R13 output holds", int'(shot_out), o0);

    step();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule